// File: doc/BRIEF.md
# Select-Framed SPI Slave Transceiver

This block is the slave end of a byte-wide SPI link. The serial clock, the active-low select line and the master-out data line come in from the pins. Each one passes through a synchronizer, and the block then works only in the system clock domain, so the serial clock must run at no more than a quarter of the system clock. Clock polarity is fixed by a parameter. Clock phase is taken from a static input and can be either of the two usual phases. Data moves most significant bit first in both directions.

The host side is a plain parallel interface. The host writes the byte to send next into a pending register. It receives each finished byte together with a one-cycle valid strobe, and it acknowledges the byte with a read strobe. If a byte finishes before the previous one has been acknowledged, an overrun flag is raised.

Framing is driven by the select line. In phase 0, every byte starts at a falling edge of select, so select must go high between bytes. In phase 1, select may stay low while bytes follow one another, and every eight clock periods make one byte. Whenever select is high, the slave stops driving its data output and ignores the serial clock. A byte that is cut off this way is thrown away.

Top module: `spi_sel_slave`

## Requirements
- R1: After reset, `miso_oe_o`, `rx_valid_o` and `overrun_o` are all 0, and `rx_data_o` is 0.
- R2: `miso_oe_o` is 1 only while the synchronized select is low. It goes to 0 within three system clocks of select rising and stays 0 while select is high.
- R3: In phase 0 (`cpha_i`=0), bit 7 of the byte pending at the select fall is on `miso_o` before the first clock edge. Each leading edge (rising when CPOL=0) samples `mosi_i`, and each trailing edge moves the next lower bit onto `miso_o`.
- R4: In phase 0, once a byte is complete, further clock edges with select held low produce no new byte. A new byte starts only after select goes high and then low again.
- R5: In phase 1 (`cpha_i`=1), the first leading edge of a byte shows bit 7, each later leading edge shows the next lower bit, and each trailing edge samples `mosi_i`. Bytes follow one another while select stays low.
- R6: After the 8th sampling edge, `rx_data_o` holds the received byte (the first bit sampled lands in bit 7), and `rx_valid_o` is high for exactly one system clock per byte.
- R7: The byte that is shifted out is taken from the pending register written by `tx_load_i`. It is loaded at the select fall in phase 0, and at the select fall and at every byte end in phase 1, so a write made during a byte is sent in the next byte.
- R8: When select rises before the 8th sampling edge, the partial byte is discarded and no `rx_valid_o` pulse is produced. Clock edges seen while select is high change nothing, and the next selected byte is received whole.
- R9: `overrun_o` goes to 1 when a byte completes while the previous byte is still unacknowledged. It stays 1 until `rx_read_i` is pulsed, and that pulse clears both the overrun flag and the unread state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpha_i | input | 1 | Clock phase select, held static while selected |
| sck_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| tx_data_i | input | DATA_W | Next byte to transmit |
| tx_load_i | input | 1 | Writes `tx_data_i` into the pending register |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new received byte |
| rx_read_i | input | 1 | Host acknowledge of the received byte |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The assertions check on every cycle that the output enable drops after the synchronized select rises and that no valid strobe appears while the slave is deselected. They also check that the completion and valid strobes last a single cycle, that the overrun flag rises only on a byte completion, and that an acknowledge with no completion in the same cycle clears the flag. Only the bench scenarios can show the serial behaviour itself: the bit order and the byte values in both phases, the need for a select toggle between phase-0 bytes, back-to-back bytes in phase 1, the pending-byte reload point, and that an aborted byte is discarded and the following byte arrives whole.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

    // Which serial clock edge samples the input line
    typedef enum logic {
        PH_LEAD_SAMPLE = 1'b0,
        PH_LEAD_SHIFT  = 1'b1
    } phase_e;

    // Edge pulses in the system clock domain
    typedef struct packed {
        logic smp;
        logic shf;
    } edge_t;

endpackage

// File: rtl/spi_sel_sync.sv
module spi_sel_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/spi_sel_core.sv
module spi_sel_core
    import spi_sel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter bit CPOL   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpha_i,
    input  logic              sck_s_i,
    input  logic              ss_s_i,
    input  logic              mosi_s_i,
    input  logic [DATA_W-1:0] tx_pend_i,
    output logic              miso_o,
    output logic              oe_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_byte_o
);

    localparam int          CW   = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    typedef struct packed {
        logic              sck_prev;
        logic              ss_prev;
        logic              active;
        logic              fresh;
        logic [CW-1:0]     cnt;
        logic [DATA_W-2:0] rx_sh;
        logic [DATA_W-1:0] tx_sh;
        logic              oe;
        logic              done;
        logic [DATA_W-1:0] rx_byte;
    } core_st_t;

    core_st_t    st_d, st_q;
    phase_e      ph;
    edge_t       ev;
    logic        sck_n;
    logic        lead, trail;
    logic [DATA_W-1:0] rx_nxt;

    assign ph = phase_e'(cpha_i);

    always_comb begin
        sck_n  = sck_s_i ^ CPOL;
        lead   = sck_n & ~st_q.sck_prev;
        trail  = ~sck_n & st_q.sck_prev;
        ev.smp = (ph == PH_LEAD_SAMPLE) ? lead  : trail;
        ev.shf = (ph == PH_LEAD_SAMPLE) ? trail : lead;
        rx_nxt = {st_q.rx_sh, mosi_s_i};

        st_d          = st_q;
        st_d.done     = 1'b0;
        st_d.sck_prev = sck_n;
        st_d.ss_prev  = ss_s_i;
        st_d.oe       = ~ss_s_i;

        if (ss_s_i) begin
            // deselected: abort and ignore the clock
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (st_q.ss_prev) begin
            // select fall: new frame, load the pending byte
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.fresh  = 1'b1;
            st_d.rx_sh  = '0;
            st_d.tx_sh  = tx_pend_i;
        end else if (st_q.active) begin
            if (ev.smp) begin
                st_d.rx_sh = rx_nxt[DATA_W-2:0];
                if (st_q.cnt == LAST) begin
                    st_d.done    = 1'b1;
                    st_d.rx_byte = rx_nxt;
                    st_d.cnt     = '0;
                    if (ph == PH_LEAD_SHIFT) begin
                        st_d.tx_sh = tx_pend_i;
                        st_d.fresh = 1'b1;
                    end else begin
                        st_d.active = 1'b0;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (ev.shf) begin
                if ((ph == PH_LEAD_SHIFT) && st_q.fresh) begin
                    st_d.fresh = 1'b0;
                end else begin
                    st_d.tx_sh = {st_q.tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ss_prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso_o    = st_q.tx_sh[DATA_W-1];
    assign oe_o      = st_q.oe;
    assign done_o    = st_q.done;
    assign rx_byte_o = st_q.rx_byte;

    // R6: a byte completion lasts one cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

endmodule

// File: rtl/spi_sel_hold.sv
module spi_sel_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              rx_read_i,
    output logic [DATA_W-1:0] tx_pend_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              overrun_o
);

    typedef struct packed {
        logic [DATA_W-1:0] pend;
        logic [DATA_W-1:0] rx;
        logic              valid;
        logic              unread;
        logic              ovr;
    } hold_st_t;

    hold_st_t h_d, h_q;

    always_comb begin
        h_d       = h_q;
        h_d.valid = done_i;
        if (tx_load_i) begin
            h_d.pend = tx_data_i;
        end
        if (rx_read_i) begin
            h_d.ovr    = 1'b0;
            h_d.unread = 1'b0;
        end
        if (done_i) begin
            h_d.rx     = rx_byte_i;
            h_d.unread = 1'b1;
            if (h_q.unread && !rx_read_i) begin
                h_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign tx_pend_o  = h_q.pend;
    assign rx_data_o  = h_q.rx;
    assign rx_valid_o = h_q.valid;
    assign overrun_o  = h_q.ovr;

    // R9: overrun only rises on a byte completion
    assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_q.ovr) |-> $past(done_i));

    // R9: an acknowledge without a completion clears the flag
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read_i && !done_i) |=> !h_q.ovr);

    // R6: valid strobe is a single cycle
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        h_q.valid |=> !h_q.valid);

endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave #(
    parameter int DATA_W = 8,
    parameter bit CPOL   = 1'b0,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpha_i,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              rx_read_i,
    output logic              overrun_o
);

    localparam logic [2:0] PIN_RST = {CPOL, 1'b1, 1'b0};

    logic [2:0]        pins_s;
    logic              sck_s, ss_s, mosi_s;
    logic              done;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] tx_pend;

    spi_sel_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sck_i, ss_n_i, mosi_i}),
        .q_o   (pins_s)
    );

    assign sck_s  = pins_s[2];
    assign ss_s   = pins_s[1];
    assign mosi_s = pins_s[0];

    spi_sel_core #(.DATA_W(DATA_W), .CPOL(CPOL)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpha_i    (cpha_i),
        .sck_s_i   (sck_s),
        .ss_s_i    (ss_s),
        .mosi_s_i  (mosi_s),
        .tx_pend_i (tx_pend),
        .miso_o    (miso_o),
        .oe_o      (miso_oe_o),
        .done_o    (done),
        .rx_byte_o (rx_byte)
    );

    spi_sel_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_data_i  (tx_data_i),
        .tx_load_i  (tx_load_i),
        .done_i     (done),
        .rx_byte_i  (rx_byte),
        .rx_read_i  (rx_read_i),
        .tx_pend_o  (tx_pend),
        .rx_data_o  (rx_data_o),
        .rx_valid_o (rx_valid_o),
        .overrun_o  (overrun_o)
    );

    // R2: pad driver released once select is seen high
    assert_oe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> !miso_oe_o);

    // R8: no received byte while deselected
    assert_no_byte_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_s && $past(ss_s) && $past(ss_s, 2)) |-> !rx_valid_o);

endmodule

// File: tb/spi_sel_slave_bench.sv
module spi_sel_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HP         = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpha = 1'b0;
    logic       sck = 1'b0;
    logic       ss_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso, miso_oe;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_read = 1'b0;
    logic       overrun;

    int total = 0;
    int bad   = 0;
    int rv_cnt = 0;
    logic [7:0] rv_last = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sel_slave u_spi_sel_slave (
        .clk(clk), .rst_n(rst_n), .cpha_i(cpha), .sck_i(sck), .ss_n_i(ss_n),
        .mosi_i(mosi), .miso_o(miso), .miso_oe_o(miso_oe),
        .tx_data_i(tx_data), .tx_load_i(tx_load), .rx_data_o(rx_data),
        .rx_valid_o(rx_valid), .rx_read_i(rx_read), .overrun_o(overrun)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rv_cnt  <= rv_cnt + 1;
            rv_last <= rx_data;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk); tx_data = b; tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); rx_read = 1'b1;
        @(negedge clk); rx_read = 1'b0;
    endtask

    task automatic sel(input logic lvl);
        @(negedge clk); ss_n = lvl;
        wclk(HP);
    endtask

    // master side of one byte (CPOL=0), MSB first
    task automatic mbyte(input logic ph, input logic [7:0] mo, output logic [7:0] mi);
        for (int i = 7; i >= 0; i--) begin
            if (!ph) begin
                @(negedge clk); mosi = mo[i];
                wclk(HP); mi[i] = miso; sck = 1'b1;
                wclk(HP); sck = 1'b0;
            end else begin
                @(negedge clk); sck = 1'b1; mosi = mo[i];
                wclk(HP); mi[i] = miso; sck = 1'b0;
                wclk(HP);
            end
        end
        wclk(HP);
    endtask

    task automatic t_reset();
        chk("R1", "miso_oe", miso_oe, 0);
        chk("R1", "rx_valid", rx_valid, 0);
        chk("R1", "overrun", overrun, 0);
        chk("R1", "rx_data", rx_data, 0);
    endtask

    task automatic t_ph0_bytes();
        logic [7:0] got;
        int n0;
        cpha = 1'b0;
        load_tx(8'h3C);
        n0 = rv_cnt;
        sel(1'b0);
        chk("R2", "oe while selected", miso_oe, 1);
        chk("R3", "msb before first edge", miso, 0);
        mbyte(1'b0, 8'hA5, got);
        chk("R3", "miso byte ph0", got, 8'h3C);
        chk("R6", "rx byte ph0", rv_last, 8'hA5);
        chk("R6", "one strobe", rv_cnt - n0, 1);
        ack();
        // R4: extra clocks without select toggle give no byte
        n0 = rv_cnt;
        mbyte(1'b0, 8'hFF, got);
        chk("R4", "no byte without toggle", rv_cnt - n0, 0);
        sel(1'b1);
        chk("R2", "oe off after deselect", miso_oe, 0);
        load_tx(8'hC3);
        sel(1'b0);
        mbyte(1'b0, 8'h5A, got);
        chk("R4", "byte after toggle", rv_last, 8'h5A);
        chk("R7", "reload at select fall", got, 8'hC3);
        chk("R4", "count after toggle", rv_cnt - n0, 1);
        ack();
        sel(1'b1);
    endtask

    task automatic t_ph1_stream();
        logic [7:0] got;
        int n0;
        cpha = 1'b1;
        load_tx(8'h81);
        n0 = rv_cnt;
        sel(1'b0);
        load_tx(8'h42);
        mbyte(1'b1, 8'h96, got);
        chk("R5", "miso byte1 ph1", got, 8'h81);
        chk("R6", "rx byte1 ph1", rv_last, 8'h96);
        ack();
        load_tx(8'h17);
        mbyte(1'b1, 8'h0F, got);
        chk("R7", "reload at byte end", got, 8'h42);
        chk("R5", "rx byte2 ph1", rv_last, 8'h0F);
        ack();
        mbyte(1'b1, 8'hE1, got);
        chk("R5", "miso byte3 ph1", got, 8'h17);
        chk("R5", "rx byte3 ph1", rv_last, 8'hE1);
        chk("R5", "three bytes one frame", rv_cnt - n0, 3);
        chk("R9", "no overrun when acked", overrun, 0);
        ack();
        sel(1'b1);
    endtask

    task automatic t_abort();
        logic [7:0] got;
        int n0;
        cpha = 1'b0;
        n0 = rv_cnt;
        sel(1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); mosi = 1'b1;
            wclk(HP); sck = 1'b1;
            wclk(HP); sck = 1'b0;
        end
        sel(1'b1);
        chk("R8", "no byte on abort", rv_cnt - n0, 0);
        chk("R2", "oe off after abort", miso_oe, 0);
        mbyte(1'b0, 8'h33, got);
        chk("R8", "clocks ignored deselected", rv_cnt - n0, 0);
        chk("R2", "oe stays off", miso_oe, 0);
        load_tx(8'h6D);
        sel(1'b0);
        mbyte(1'b0, 8'h29, got);
        chk("R8", "whole byte after abort", rv_last, 8'h29);
        chk("R8", "miso after abort", got, 8'h6D);
        ack();
        sel(1'b1);
    endtask

    task automatic t_overrun();
        logic [7:0] got;
        cpha = 1'b1;
        sel(1'b0);
        mbyte(1'b1, 8'h11, got);
        chk("R9", "no overrun first", overrun, 0);
        mbyte(1'b1, 8'h22, got);
        chk("R9", "overrun set", overrun, 1);
        chk("R9", "data overwritten", rx_data, 8'h22);
        wclk(4);
        chk("R9", "overrun sticky", overrun, 1);
        ack();
        wclk(1);
        chk("R9", "overrun cleared", overrun, 0);
        mbyte(1'b1, 8'h44, got);
        chk("R9", "no overrun after ack", overrun, 0);
        ack();
        sel(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wclk(3);
        rst_n = 1'b1;
        wclk(4);
        t_reset();
        t_ph0_bytes();
        t_ph1_stream();
        t_abort();
        t_overrun();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule